// File: doc/BRIEF.md
# Register-Mapped Serial Communications Interface

This block is an asynchronous serial port that a small CPU drives through a byte-wide register bus. It holds a baud register, two control registers, a status register and a data register. It sends 8-bit characters framed by a low start bit and a high stop bit, least significant bit first, and it receives such characters into a receive data register. Four status flags track the transmitter and the receiver: transmit-empty, transmit-complete, receive-full and overrun. An interrupt request is raised when a flag and its matching enable are both set.

Software loads a character by writing the data register. The character waits in a pending holder until the shifter is idle and the transmitter is enabled. Received characters are collected by reading the status register and then the data register. A bootstrap selection sampled during reset presets the bit rate and turns both directions on.

Transmit state machine `sci_tx`:
- `TX_IDLE` goes to `TX_START` on a load.
- `TX_START` goes to `TX_DATA` after one bit period.
- `TX_DATA` goes to `TX_STOP` after the eighth data bit.
- `TX_STOP` goes back to `TX_IDLE` after one bit period and pulses the finish signal.

Receive state machine `sci_rx`:
- `RX_IDLE` goes to `RX_START` when the line is seen low while the receiver is enabled.
- `RX_START` checks the line at half a bit. It goes to `RX_DATA` if the line is still low, and back to `RX_IDLE` otherwise.
- `RX_DATA` takes one sample per bit period and goes to `RX_STOP` after eight samples.
- `RX_STOP` samples the stop bit. If the stop bit is high it delivers the character and goes to `RX_IDLE`. If it is low it goes to `RX_HOLD`.
- `RX_HOLD` waits for the line to go high, then returns to `RX_IDLE`.
- A cleared receiver enable forces the receive machine to `RX_IDLE` from any state.

Top module: `sci_core`

## Requirements
- R1: Register offsets are baud 0, control 1 at 1, control 2 at 2, status at 3 and data at 4. Baud and the two control registers read back the value last written. Writes to status are ignored.
- R2: After reset, baud, control 1 and control 2 read 0x00. Status reads 0xC0: transmit-empty is bit 7, transmit-complete is bit 6, receive-full is bit 5 and overrun is bit 3.
- R3: If reset is held with the special-mode input high and the mode-A input low, baud reads 0x33 and control 2 reads 0x12 after reset. With any other mode input combination both read 0x00.
- R4: One bit lasts 2*(baud+1) clock cycles and one frame lasts 10 bit times. Transmit-complete sets exactly 10 bit times after the start bit begins on the line.
- R5: The transmit line idles high. A frame is a low start bit, eight data bits sent least significant bit first, and a high stop bit.
- R6: A write to the data register clears transmit-empty and transmit-complete. Transmit-empty sets again once the shifter takes the character, and transmit-complete sets when the frame ends with nothing pending. Transmission requires the transmit enable, which is control 2 bit 1. While that bit is clear nothing is sent and both flags stay clear.
- R7: With the receive enable set (control 2 bit 4), a frame on the receive line is sampled at mid-bit. Its character appears in the data register and receive-full sets.
- R8: A character that completes while receive-full is still set also sets overrun. The newer character replaces the older one.
- R9: Receive-full and overrun clear only when a status read that sees either flag set is followed by a data-register read. A data-register read alone clears nothing.
- R10: A frame with a low stop bit is discarded without changing the flags or the data register. The next good frame after the line returns high is received normally.
- R11: While the receive enable is clear, activity on the receive line has no effect.
- R12: The interrupt request is high exactly when one of these pairs is set: transmit interrupt enable (control 2 bit 7) with transmit-empty, transmit-complete interrupt enable (bit 6) with transmit-complete, or receive interrupt enable (bit 5) with receive-full or overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_special | input | 1 | Special operating mode selection, sampled during reset |
| mode_a | input | 1 | Mode-A selection, sampled during reset |
| cs | input | 1 | Register access strobe, one cycle per access |
| we | input | 1 | High for a write, low for a read |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid combinationally in the access cycle |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt request |

## Verification
A transmit machine stuck in the wrong state shows on the transmit line within one bit period. A bit counter that is off by one moves the rise of transmit-complete away from exactly ten bit times, and that is visible on the interrupt line with single-cycle resolution. A wrong receive state or a wrong sample point shows at the first status and data reads after a frame, as a wrong character, a missing receive-full, or a spurious 0xFF frame after a bad stop bit. A wrong clear-sequence state shows as flags that survive, or vanish too early, across the two-read sequence.

// File: rtl/sci_pkg.sv
package sci_pkg;
    localparam int A_BAUD = 0;
    localparam int A_CTL1 = 1;
    localparam int A_CTL2 = 2;
    localparam int A_STAT = 3;
    localparam int A_DATA = 4;

    // control 2 bit positions
    localparam int C2_TIE  = 7;
    localparam int C2_TCIE = 6;
    localparam int C2_RIE  = 5;
    localparam int C2_RE   = 4;
    localparam int C2_TE   = 1;

    localparam logic [7:0] BOOT_BAUD = 8'h33;
    localparam logic [7:0] BOOT_CTL2 = 8'h12;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD} rx_state_e;
endpackage

// File: rtl/sci_tx.sv
module sci_tx import sci_pkg::*; #(
    parameter int DBITS = 8,
    parameter int CW    = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CW-1:0]    period,
    input  logic             start,
    input  logic [DBITS-1:0] din,
    output logic             busy,
    output logic             fin,
    output logic             txd
);
    localparam int IW = (DBITS > 1) ? $clog2(DBITS) : 1;

    tx_state_e        st, nxt;
    logic [CW-1:0]    cnt;
    logic [IW-1:0]    idx;
    logic [DBITS-1:0] sh;
    logic             bit_end;

    assign bit_end = (cnt == period - CW'(1));

    always_comb begin
        nxt = st;
        unique case (st)
            TX_IDLE:  if (start) nxt = TX_START;
            TX_START: if (bit_end) nxt = TX_DATA;
            TX_DATA:  if (bit_end && idx == IW'(DBITS-1)) nxt = TX_STOP;
            TX_STOP:  if (bit_end) nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= TX_IDLE;
        else     st <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            idx <= '0;
            sh  <= '0;
            txd <= 1'b1;
        end else begin
            if (st == TX_IDLE) cnt <= '0;
            else               cnt <= bit_end ? '0 : cnt + CW'(1);
            unique case (st)
                TX_IDLE: if (start) begin
                    sh  <= din;
                    txd <= 1'b0;
                end
                TX_START: if (bit_end) begin
                    txd <= sh[0];
                    idx <= '0;
                end
                TX_DATA: if (bit_end) begin
                    if (idx == IW'(DBITS-1)) txd <= 1'b1;
                    else begin
                        sh  <= sh >> 1;
                        txd <= sh[1];
                        idx <= idx + IW'(1);
                    end
                end
                TX_STOP: ;
            endcase
        end
    end

    assign busy = (st != TX_IDLE);
    assign fin  = (st == TX_STOP) && bit_end;

    p_start_low_r5: assert property (@(posedge clk) disable iff (rst)
        (st == TX_START) |-> !txd);
    p_idle_high_r5: assert property (@(posedge clk) disable iff (rst)
        (st == TX_IDLE) |-> txd);
endmodule

// File: rtl/sci_rx.sv
module sci_rx import sci_pkg::*; #(
    parameter int DBITS = 8,
    parameter int CW    = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CW-1:0]    period,
    input  logic [CW-1:0]    half,
    input  logic             rxd_in,
    output logic             valid,
    output logic [DBITS-1:0] dout
);
    localparam int IW = (DBITS > 1) ? $clog2(DBITS) : 1;

    rx_state_e        st, nxt;
    logic [CW-1:0]    cnt;
    logic [IW-1:0]    idx;
    logic [DBITS-1:0] sh;
    logic             s1, line;
    logic             bit_end, half_end;

    assign bit_end  = (cnt == period - CW'(1));
    assign half_end = (cnt == half - CW'(1));

    always_comb begin
        nxt = st;
        if (!en) nxt = RX_IDLE;
        else begin
            unique case (st)
                RX_IDLE:  if (!line) nxt = RX_START;
                RX_START: if (half_end) nxt = line ? RX_IDLE : RX_DATA;
                RX_DATA:  if (bit_end && idx == IW'(DBITS-1)) nxt = RX_STOP;
                RX_STOP:  if (bit_end) nxt = line ? RX_IDLE : RX_HOLD;
                RX_HOLD:  if (line) nxt = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= RX_IDLE;
        else     st <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1    <= 1'b1;
            line  <= 1'b1;
            cnt   <= '0;
            idx   <= '0;
            sh    <= '0;
            valid <= 1'b0;
            dout  <= '0;
        end else begin
            s1    <= rxd_in;
            line  <= s1;
            valid <= 1'b0;
            unique case (st)
                RX_IDLE, RX_HOLD: cnt <= '0;
                RX_START: begin
                    cnt <= half_end ? '0 : cnt + CW'(1);
                    if (half_end) idx <= '0;
                end
                RX_DATA: begin
                    cnt <= bit_end ? '0 : cnt + CW'(1);
                    if (bit_end) begin
                        sh  <= {line, sh[DBITS-1:1]};
                        idx <= idx + IW'(1);
                    end
                end
                RX_STOP: begin
                    cnt <= bit_end ? '0 : cnt + CW'(1);
                    if (bit_end && line && en) begin
                        valid <= 1'b1;
                        dout  <= sh;
                    end
                end
            endcase
        end
    end

    p_gate_r11: assert property (@(posedge clk) disable iff (rst)
        !en |=> (st == RX_IDLE) && !valid);
    p_stop_high_r10: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(line));
endmodule

// File: rtl/sci_core.sv
module sci_core import sci_pkg::*; #(
    parameter int DBITS  = 8,
    parameter int BAUD_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_special,
    input  logic             mode_a,
    input  logic             cs,
    input  logic             we,
    input  logic [2:0]       addr,
    input  logic [DBITS-1:0] wdata,
    output logic [DBITS-1:0] rdata,
    input  logic             rxd,
    output logic             txd,
    output logic             irq
);
    localparam int CW = BAUD_W + 2;

    logic [BAUD_W-1:0] baud_q;
    logic [DBITS-1:0]  ctl1_q, ctl2_q, hold_q, rbuf_q, stat;
    logic              tdre, tc, rdrf, ovr, armed, pend;
    logic [CW-1:0]     period, half;
    logic              wr, rd, load, tx_busy, tx_fin, rx_valid;
    logic [DBITS-1:0]  rx_dout;

    assign half   = CW'(baud_q) + CW'(1);
    assign period = half << 1;
    assign wr     = cs && we;
    assign rd     = cs && !we;
    assign load   = pend && ctl2_q[C2_TE] && !tx_busy;
    assign stat   = {tdre, tc, rdrf, 1'b0, ovr, 3'b000};

    always_ff @(posedge clk) begin
        if (rst) begin
            baud_q <= (mode_special && !mode_a) ? BAUD_W'(BOOT_BAUD) : '0;
            ctl2_q <= (mode_special && !mode_a) ? BOOT_CTL2 : '0;
            ctl1_q <= '0;
            hold_q <= '0;
            rbuf_q <= '0;
            tdre   <= 1'b1;
            tc     <= 1'b1;
            rdrf   <= 1'b0;
            ovr    <= 1'b0;
            armed  <= 1'b0;
            pend   <= 1'b0;
        end else begin
            if (wr && addr == 3'(A_BAUD)) baud_q <= BAUD_W'(wdata);
            if (wr && addr == 3'(A_CTL1)) ctl1_q <= wdata;
            if (wr && addr == 3'(A_CTL2)) ctl2_q <= wdata;
            // transmit side
            if (tx_fin && !pend) tc <= 1'b1;
            if (wr && addr == 3'(A_DATA)) begin
                hold_q <= wdata;
                pend   <= 1'b1;
                tdre   <= 1'b0;
                tc     <= 1'b0;
            end else if (load) begin
                pend <= 1'b0;
                tdre <= 1'b1;
            end
            // receive side
            if (rx_valid) begin
                rbuf_q <= rx_dout;
                rdrf   <= 1'b1;
                if (rdrf) ovr <= 1'b1;
                armed  <= 1'b0;
            end else begin
                if (rd && addr == 3'(A_STAT) && (rdrf || ovr)) armed <= 1'b1;
                if (rd && addr == 3'(A_DATA) && armed) begin
                    rdrf  <= 1'b0;
                    ovr   <= 1'b0;
                    armed <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        unique case (addr)
            3'(A_BAUD): rdata = DBITS'(baud_q);
            3'(A_CTL1): rdata = ctl1_q;
            3'(A_CTL2): rdata = ctl2_q;
            3'(A_STAT): rdata = stat;
            3'(A_DATA): rdata = rbuf_q;
            default:    rdata = '0;
        endcase
    end

    assign irq = (ctl2_q[C2_TIE] && tdre) || (ctl2_q[C2_TCIE] && tc) ||
                 (ctl2_q[C2_RIE] && (rdrf || ovr));

    sci_tx #(.DBITS(DBITS), .CW(CW)) u_tx (
        .clk(clk), .rst(rst), .period(period), .start(load), .din(hold_q),
        .busy(tx_busy), .fin(tx_fin), .txd(txd)
    );

    sci_rx #(.DBITS(DBITS), .CW(CW)) u_rx (
        .clk(clk), .rst(rst), .en(ctl2_q[C2_RE]), .period(period), .half(half),
        .rxd_in(rxd), .valid(rx_valid), .dout(rx_dout)
    );

    p_reset_flags_r2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (stat == 8'hC0));
    p_overrun_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> $past(rdrf));
    p_wr_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == 3'(A_DATA)) |=> !tc && pend);
    p_irq_source_r12: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ctl2_q[C2_TIE] || ctl2_q[C2_TCIE] || ctl2_q[C2_RIE]));
    p_tdre_load_r6: assert property (@(posedge clk) disable iff (rst)
        (load && !(wr && addr == 3'(A_DATA))) |=> tdre && tx_busy);
endmodule

// File: tb/sci_core_test.sv
module sci_core_test;
    localparam int CLK_P = 10;

    logic       clk = 0, rst = 1, mode_special = 0, mode_a = 0;
    logic       cs = 0, we = 0, rxd = 1;
    logic [2:0] addr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       txd, irq;
    int         n_run = 0, n_fail = 0;
    int         P = 8;

    sci_core uut (.clk(clk), .rst(rst), .mode_special(mode_special), .mode_a(mode_a),
        .cs(cs), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata),
        .rxd(rxd), .txd(txd), .irq(irq));

    always #(CLK_P/2) clk = ~clk;

    function automatic int bit_len(input int b);
        return 2 * (b + 1);
    endfunction

    function automatic logic [7:0] exp_stat(input logic e, input logic c,
                                            input logic f, input logic o);
        return {e, c, f, 1'b0, o, 3'b000};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic do_reset(input logic sp, input logic ma);
        @(negedge clk);
        mode_special = sp; mode_a = ma; rst = 1;
        repeat (3) @(negedge clk);
        rst = 0; mode_special = 0; mode_a = 0;
    endtask

    task automatic bus_wr(input int a, input logic [7:0] d);
        cs = 1; we = 1; addr = 3'(a); wdata = d;
        @(negedge clk);
        cs = 0; we = 0;
    endtask

    task automatic bus_rd(input int a, output logic [7:0] d);
        cs = 1; we = 0; addr = 3'(a);
        #1 d = rdata;
        @(negedge clk);
        cs = 0;
    endtask

    task automatic set_baud(input int b);
        bus_wr(0, 8'(b));
        P = bit_len(b);
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stop);
        rxd = 0;
        repeat (P) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (P) @(negedge clk);
        end
        rxd = stop;
        repeat (P) @(negedge clk);
        rxd = 1;
        repeat (P) @(negedge clk);
    endtask

    // write a byte with TE and TCIE set, then follow the frame on txd
    task automatic send_tx(input logic [7:0] b);
        logic [7:0] v, got;
        int t_irq;
        got = 0; t_irq = -1;
        bus_wr(4, b);
        bus_rd(3, v);
        check("R6 flags cleared by data write", v, exp_stat(0, 0, 0, 0));
        // now at c = 0: start bit has just begun on the line
        for (int c = 0; c <= 11 * P; c++) begin
            if (c == P / 2) check("R5 start bit low", txd, 0);
            for (int i = 0; i < 8; i++)
                if (c == P * (i + 1) + P / 2) got[i] = txd;
            if (c == 9 * P + P / 2) check("R5 stop bit high", txd, 1);
            if (irq && t_irq < 0) t_irq = c;
            @(negedge clk);
        end
        check("R5 serialized byte", got, b);
        check("R4 frame length to transmit-complete", t_irq, 10 * P);
        bus_rd(3, v);
        check("R6 flags set after frame", v, exp_stat(1, 1, 0, 0));
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v, a, b;
        void'($urandom(32'd20240611));

        // reset state
        do_reset(0, 0);
        bus_rd(0, v); check("R2 baud after reset", v, 8'h00);
        bus_rd(1, v); check("R2 ctl1 after reset", v, 8'h00);
        bus_rd(2, v); check("R2 ctl2 after reset", v, 8'h00);
        bus_rd(3, v); check("R2 status after reset", v, 8'hC0);
        check("R12 irq idle after reset", irq, 0);

        // register window
        bus_wr(1, 8'h5A); bus_rd(1, v); check("R1 ctl1 readback", v, 8'h5A);
        set_baud(3);     bus_rd(0, v); check("R1 baud readback", v, 8'h03);
        bus_wr(2, 8'h52); bus_rd(2, v); check("R1 ctl2 readback", v, 8'h52);
        bus_wr(3, 8'hFF); bus_rd(3, v); check("R1 status ignores writes", v, 8'hC0);

        // transmit, two bit rates
        send_tx(8'hA5);
        send_tx(8'h01);
        for (int k = 0; k < 3; k++) send_tx(8'($urandom));
        set_baud(1);
        send_tx(8'h80);
        send_tx(8'($urandom));
        set_baud(3);

        // transmit disabled
        bus_wr(2, 8'h10);
        bus_wr(4, 8'h3C);
        for (int c = 0; c < 12 * P; c++) begin
            if (!txd) begin check("R6 no frame while TE clear", txd, 1); break; end
            @(negedge clk);
        end
        bus_rd(3, v); check("R6 flags stay clear while TE clear", v, exp_stat(0, 0, 0, 0));
        bus_wr(2, 8'h12);
        repeat (11 * P) @(negedge clk);
        bus_rd(3, v); check("R6 pending sent once TE set", v, exp_stat(1, 1, 0, 0));

        // receive random bytes
        for (int k = 0; k < 4; k++) begin
            a = (k == 0) ? 8'hC3 : 8'($urandom);
            send_rx(a, 1);
            bus_rd(3, v); check("R7 receive-full set", v, exp_stat(1, 1, 1, 0));
            bus_rd(4, v); check("R7 received byte", v, a);
            bus_rd(3, v); check("R9 flags cleared by two reads", v, exp_stat(1, 1, 0, 0));
        end

        // data read alone does not clear
        send_rx(8'h5E, 1);
        bus_rd(4, v); check("R7 received byte", v, 8'h5E);
        bus_rd(3, v); check("R9 data read alone keeps flag", v, exp_stat(1, 1, 1, 0));
        bus_rd(4, v);
        bus_rd(3, v); check("R9 cleared after status then data", v, exp_stat(1, 1, 0, 0));

        // overrun
        a = 8'($urandom); b = 8'($urandom);
        send_rx(a, 1);
        send_rx(b, 1);
        bus_rd(3, v); check("R8 overrun set", v, exp_stat(1, 1, 1, 1));
        bus_rd(4, v); check("R8 newer byte kept", v, b);
        bus_rd(3, v); check("R8 overrun cleared by sequence", v, exp_stat(1, 1, 0, 0));

        // bad stop bit
        send_rx(8'h00, 0);
        repeat (2 * P) @(negedge clk);
        bus_rd(3, v); check("R10 bad frame discarded", v, exp_stat(1, 1, 0, 0));
        bus_rd(4, v); check("R10 data register unchanged", v, b);
        send_rx(8'h6B, 1);
        bus_rd(3, v); check("R10 next frame accepted", v, exp_stat(1, 1, 1, 0));
        bus_rd(4, v); check("R10 next frame byte", v, 8'h6B);
        bus_rd(3, v); bus_rd(4, v);

        // receiver disabled
        bus_wr(2, 8'h02);
        send_rx(8'h11, 1);
        bus_rd(3, v); check("R11 line ignored with RE clear", v, exp_stat(1, 1, 0, 0));
        bus_rd(4, v); check("R11 data unchanged with RE clear", v, 8'h6B);

        // interrupt pairs
        bus_wr(2, 8'h30);
        check("R12 irq low before receive", irq, 0);
        send_rx(8'h77, 1);
        check("R12 irq from receive-full", irq, 1);
        bus_rd(3, v); bus_rd(4, v);
        check("R12 irq drops after clear", irq, 0);
        bus_wr(2, 8'h80);
        check("R12 irq from transmit-empty", irq, 1);
        bus_wr(2, 8'h40);
        check("R12 irq from transmit-complete", irq, 1);

        // bootstrap preload
        do_reset(1, 0);
        bus_rd(0, v); check("R3 bootstrap baud", v, 8'h33);
        bus_rd(2, v); check("R3 bootstrap ctl2", v, 8'h12);
        bus_rd(3, v); check("R2 status after bootstrap reset", v, 8'hC0);
        do_reset(1, 1);
        bus_rd(0, v); check("R3 no preload with mode-A set", v, 8'h00);
        bus_rd(2, v); check("R3 ctl2 zero with mode-A set", v, 8'h00);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule